// File: doc/BRIEF.md
# Framed Slot Serialiser for a Synchronous Link

This block feeds one serial wire of a synchronous high-speed link. It produces an unbroken stream of 9-bit bytes grouped into frames. Each frame opens with a SYNC control byte. It is followed by one byte for every terminal slot, and the slots always come in ascending order. A slot whose terminal has a character waiting carries that character behind a 0 type bit. A slot with nothing to send carries a NULL control byte behind a 1 type bit. With the default 32 slots a frame is always 33 bytes, or 297 bit times, whether or not any terminal is attached.

Terminal-side logic presents, per slot, an availability flag and an 8-bit character. The block pulses that slot's acknowledge in the cycle the character is taken into a byte, so the terminal side can drop or replace it. A bit-clock enable advances the line one bit per enabled cycle. The next byte is chosen on the same enabled cycle that retires the last bit of the current byte, so there is never an idle bit. A byte-request flag changes level each time a new byte is taken.

Top module: `frame_tx`

## Requirements
- R1: After reset the line carries a SYNC byte as its first byte: `ser_out` is 1 (control type bit), `byte_req` is 0, no `slot_ack` bit is set, and the byte after that SYNC belongs to slot 1.
- R2: Bytes follow the order SYNC, slot 1, slot 2, ..., slot NUM_SLOTS, SYNC, ... with no gap, so every frame holds exactly NUM_SLOTS+1 bytes (33 by default).
- R3: A slot whose `slot_avail` bit is 1 when its byte is taken is sent as type bit 0 followed by its 8-bit character, most-significant bit first. Slot k (1-based) uses `slot_avail[k-1]` and `slot_data[8k-1:8k-8]`.
- R4: A slot whose `slot_avail` bit is 0 is sent as a NULL byte: type bit 1 followed by NULL_CODE (default 8'h00). The value on its `slot_data` field has no effect on the line.
- R5: A SYNC byte is type bit 1 followed by SYNC_CODE (default 8'hA5), most-significant bit first.
- R6: `slot_ack[k-1]` is high for exactly the one enabled cycle in which slot k's character is taken into a byte. It is never high for an unavailable slot, and at most one ack bit is high at a time.
- R7: `ser_out` moves to the next bit only on a cycle with `bit_en` high and otherwise holds. The first bit of a byte directly follows the last bit of the previous byte.
- R8: `byte_req` changes value exactly once per byte taken, on the enabled cycle that retires a byte's last bit, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-time enable; one line bit per high cycle |
| slot_avail | input | NUM_SLOTS | Per-slot flag: a character is waiting |
| slot_data | input | 8*NUM_SLOTS | Per-slot characters, slot k in bits 8k-1 down to 8k-8 |
| slot_ack | output | NUM_SLOTS | Per-slot pulse: character taken |
| ser_out | output | 1 | Serial line, type bit first then payload MSB first |
| byte_req | output | 1 | Level changes each time a new byte is taken |

## Verification
Three things can happen in the same cycle: the enabled cycle that retires a byte's last bit also takes the next byte, acknowledges a slot, and flips the request flag. When the retiring byte is the last terminal slot, that cycle also wraps the slot counter to SYNC. The bench provokes these collisions with frames in which every slot, no slot and alternate slots hold characters, and with gaps of 0 to 2 idle cycles between enable pulses. A bit-by-bit model decides the expected line bit, ack vector and flag level. Each collision cycle is judged by its ack vector, checked just before the edge, and then by the next line bits and the flag level after the edge.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam int CHAR_W = 8;
  localparam int BYTE_W = CHAR_W + 1;

  typedef logic [BYTE_W-1:0] xbyte_t;

  // Type bit in the MSB so it leaves the shifter first.
  function automatic xbyte_t make_byte(input logic ctrl, input logic [CHAR_W-1:0] payload);
    return {ctrl, payload};
  endfunction

  // Slot position after a byte is taken: wraps to 1 after the SYNC position.
  function automatic int unsigned next_pos(input int unsigned pos, input int unsigned frame_len);
    return (pos >= frame_len) ? 1 : pos + 1;
  endfunction
endpackage

// File: rtl/ftx_shifter.sv
module ftx_shifter
  import ftx_pkg::*;
#(
  parameter xbyte_t RESET_BYTE = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_en,
  input  xbyte_t next_byte,
  output logic   ser_out,
  output logic   fetch,
  output logic   byte_req
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] bit_cnt;
  xbyte_t           shreg;

  // The enabled cycle of the last bit takes the next byte: no idle bit.
  assign fetch   = bit_en && (bit_cnt == LAST);
  assign ser_out = shreg[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= RESET_BYTE;
      bit_cnt  <= '0;
      byte_req <= 1'b0;
    end else if (bit_en) begin
      if (fetch) begin
        shreg    <= next_byte;
        bit_cnt  <= '0;
        byte_req <= ~byte_req;
      end else begin
        shreg    <= {shreg[BYTE_W-2:0], 1'b0};
        bit_cnt  <= bit_cnt + 1'b1;
      end
    end
  end

  p_req_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> (byte_req != $past(byte_req)));
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |=> $stable(byte_req));
  p_line_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);
endmodule

// File: rtl/ftx_slot_sel.sv
module ftx_slot_sel
  import ftx_pkg::*;
#(
  parameter int                NUM_SLOTS = 32,
  parameter logic [CHAR_W-1:0] SYNC_CODE = 8'hA5,
  parameter logic [CHAR_W-1:0] NULL_CODE = 8'h00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch,
  input  logic [NUM_SLOTS-1:0]        slot_avail,
  input  logic [NUM_SLOTS*CHAR_W-1:0] slot_data,
  output xbyte_t                      next_byte,
  output logic [NUM_SLOTS-1:0]        slot_ack
);
  localparam int FRAME_LEN = NUM_SLOTS + 1;
  localparam int SLOT_W    = $clog2(FRAME_LEN + 1);
  localparam logic [SLOT_W-1:0] SYNC_POS = SLOT_W'(FRAME_LEN);

  logic [SLOT_W-1:0]    slot_pos;
  logic [NUM_SLOTS-1:0] hit;
  logic [CHAR_W-1:0]    sel_char;
  logic                 sel_avail;
  logic                 sync_due;

  assign sync_due = (slot_pos == SYNC_POS);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
    assign hit[g] = (slot_pos == SLOT_W'(g + 1));
  end

  always_comb begin
    sel_char = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hit[i]) sel_char = sel_char | slot_data[i*CHAR_W +: CHAR_W];
    end
  end

  assign sel_avail = |(hit & slot_avail);

  always_comb begin
    if (sync_due)       next_byte = make_byte(1'b1, SYNC_CODE);
    else if (sel_avail) next_byte = make_byte(1'b0, sel_char);
    else                next_byte = make_byte(1'b1, NULL_CODE);
  end

  assign slot_ack = fetch ? (hit & slot_avail) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     slot_pos <= SLOT_W'(1);
    else if (fetch) slot_pos <= SLOT_W'(next_pos(int'(slot_pos), FRAME_LEN));
  end

  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pos >= SLOT_W'(1)) && (slot_pos <= SYNC_POS));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && sync_due) |=> (slot_pos == SLOT_W'(1)));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !sync_due) |=> (slot_pos == $past(slot_pos) + 1'b1));
  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_ack));
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import ftx_pkg::*;
#(
  parameter int                NUM_SLOTS = 32,
  parameter logic [CHAR_W-1:0] SYNC_CODE = 8'hA5,
  parameter logic [CHAR_W-1:0] NULL_CODE = 8'h00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_en,
  input  logic [NUM_SLOTS-1:0]        slot_avail,
  input  logic [NUM_SLOTS*CHAR_W-1:0] slot_data,
  output logic [NUM_SLOTS-1:0]        slot_ack,
  output logic                        ser_out,
  output logic                        byte_req
);
  localparam xbyte_t FIRST_BYTE = make_byte(1'b1, SYNC_CODE);

  logic   fetch;
  xbyte_t next_byte;

  ftx_slot_sel #(
    .NUM_SLOTS(NUM_SLOTS),
    .SYNC_CODE(SYNC_CODE),
    .NULL_CODE(NULL_CODE)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch     (fetch),
    .slot_avail(slot_avail),
    .slot_data (slot_data),
    .next_byte (next_byte),
    .slot_ack  (slot_ack)
  );

  ftx_shifter #(
    .RESET_BYTE(FIRST_BYTE)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .next_byte(next_byte),
    .ser_out  (ser_out),
    .fetch    (fetch),
    .byte_req (byte_req)
  );

  p_ack_on_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_ack) |-> fetch);
  p_data_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_ack) |=> !ser_out);
  p_ctrl_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !(|slot_ack)) |=> ser_out);
endmodule

// File: tb/tb_frame_tx.sv
module tb_frame_tx;
  localparam int N      = 32;
  localparam int FRAMES = 6;
  localparam logic [7:0] SYNC_V = 8'hA5;
  localparam logic [7:0] NULL_V = 8'h00;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bit_en = 1'b0;
  logic [N-1:0]   avail = '0;
  logic [N*8-1:0] data = '0;
  logic [N-1:0]   ack;
  logic           ser_out;
  logic           byte_req;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  frame_tx #(.NUM_SLOTS(N), .SYNC_CODE(SYNC_V), .NULL_CODE(NULL_V)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .slot_avail(avail),
    .slot_data(data), .slot_ack(ack), .ser_out(ser_out), .byte_req(byte_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-frame availability pattern and characters.
  task automatic load_frame(input int f);
    for (int k = 0; k < N; k++) begin
      logic a;
      case (f % 4)
        0:       a = 1'b0;
        1:       a = 1'b1;
        2:       a = (k % 2) == 1;
        default: a = ((k * 5 + f) % 3) == 0;
      endcase
      avail[k] = a;
      data[k*8 +: 8] = a ? 8'(k * 37 + f * 11 + 3) : 8'(8'hFF ^ k);
    end
  endtask

  initial begin : main
    logic [8:0] exp_byte;
    string      tag;
    int         exp_slot;
    logic       exp_req;
    int         frm;
    int         bitctr;
    logic [N-1:0] exp_ack;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 line", 32'(ser_out), 32'd1);
    chk("R1 req", 32'(byte_req), 32'd0);
    chk("R1 ack", 32'(ack), 32'd0);

    exp_byte = {1'b1, SYNC_V};
    tag      = "R2,R5 sync";
    exp_slot = 1;
    exp_req  = 1'b0;
    frm      = 0;
    bitctr   = 0;

    for (int byt = 0; byt < FRAMES * (N + 1); byt++) begin
      if (exp_slot == 1 && exp_byte == {1'b1, SYNC_V}) begin
        load_frame(frm);
        frm++;
      end
      for (int b = 8; b >= 0; b--) begin
        int g;
        g = bitctr % 3;
        bitctr++;
        for (int i = 0; i < g; i++) begin
          chk({"R7 hold ", tag}, 32'(ser_out), 32'(exp_byte[b]));
          @(negedge clk);
        end
        chk(tag, 32'(ser_out), 32'(exp_byte[b]));
        chk("R6 idle ack", 32'(ack), 32'd0);
        bit_en = 1'b1;
        #1;
        exp_ack = '0;
        if (b == 0 && exp_slot <= N && avail[exp_slot-1]) exp_ack[exp_slot-1] = 1'b1;
        chk("R6 ack", 32'(ack), 32'(exp_ack));
        @(negedge clk);
        bit_en = 1'b0;
        if (b == 0) begin
          if (exp_slot == N + 1) begin
            exp_byte = {1'b1, SYNC_V};
            tag      = "R2,R5 sync";
            exp_slot = 1;
          end else if (avail[exp_slot-1]) begin
            exp_byte = {1'b0, data[(exp_slot-1)*8 +: 8]};
            tag      = "R3 data";
            avail[exp_slot-1] = 1'b0;
            exp_slot++;
          end else begin
            exp_byte = {1'b1, NULL_V};
            tag      = "R4 null";
            exp_slot++;
          end
          exp_req = ~exp_req;
          chk("R8 req", 32'(byte_req), 32'(exp_req));
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule